// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block holds the digital side of a low-supply reset. A comparator outside the block raises a flag when the supply sags under its threshold. Once software has switched the monitor on and chosen it as a reset source, and once the monitor has settled, that flag drives both an active-low reset to the processor core and the active-low external reset pin. When the supply recovers, the reset lets go a few cycles later. There is no extra wait in that case, because the long start-up wait follows only a real power-on.

The monitor enable is set by power-on and by nothing else, so a monitor that software has turned off stays off across a software reset. Whenever the enable goes from off to on, a settling counter starts. Until it expires, the comparator cannot cause a reset, and a ready status shows whether it has expired. A cause flag reads 1 after power-on or after a supply-fail reset, which tells software that RAM contents may no longer be valid. A software reset clears the flag only when neither of those events happens in the same cycle.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: When the monitor is enabled, selected and ready, a high level on `vlow_async_i` drives `core_rst_n_o` and `pin_rst_n_o` low on the third clock edge after it is applied. Both stay low while the level stays high.
- R2: When `vlow_async_i` returns low, both reset outputs go high on the third clock edge. No power-on delay is added.
- R3: While `por_i` is high, the monitor enable (`mon_en_o`), the source selection and the cause flag (`flag_o`) are all set to 1.
- R4: Both reset outputs are low while `por_i` is high. They stay low for the first POR_DLY edges after `por_i` falls and go high on edge POR_DLY+1.
- R5: `swrst_req_i` drives both reset outputs low in the following cycle and leaves the monitor enable and the selection unchanged.
- R6: A cycle with `wr_en_i` high loads `wr_en_data_i` into the monitor enable, which is visible on `mon_en_o` in the next cycle.
- R7: A 0-to-1 write of the enable restarts the settling count. `mon_rdy_o` rises on edge STAB_CYC+1 after the write edge, and a low-supply level has no effect on the reset outputs until then. The same count also starts on power-on.
- R8: A cycle with `wr_src_i` high loads `wr_src_data_i` into the source selection. A value of 0 makes the reset outputs ignore the comparator, and a value of 1 restores R1.
- R9: While the monitor enable is 0, `mon_rdy_o` is 0 from the second edge on and the comparator has no effect on the reset outputs.
- R10: A supply-fail reset sets `flag_o` to 1. A software reset clears it in the next cycle unless a power-on or a supply-fail reset happens in the same cycle, in which case it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Raw power-on pulse, active high, synchronous reset of the block |
| vlow_async_i | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| swrst_req_i | input | 1 | Software reset request, held high for the reset duration |
| wr_en_i | input | 1 | Write strobe for the monitor enable |
| wr_en_data_i | input | 1 | Value written to the monitor enable |
| wr_src_i | input | 1 | Write strobe for the reset-source selection |
| wr_src_data_i | input | 1 | 1 selects the monitor as a reset source |
| core_rst_n_o | output | 1 | Registered active-low core reset |
| pin_rst_n_o | output | 1 | Registered active-low external pin reset |
| flag_o | output | 1 | Power-on / supply-fail cause flag |
| mon_en_o | output | 1 | Monitor enable readback |
| mon_rdy_o | output | 1 | Monitor settled status |

## Verification
Each result has its own latency, counted in clock edges after the edge that captures the stimulus. Writes, software reset and the cause flag take one edge. A comparator change takes three (two synchronizer flops and the output register). Ready rises on edge STAB_CYC+1 after an enabling write, and the start-up release comes on edge POR_DLY+1 after power-on falls. The driver task puts each expected value in a queue stamped with its due cycle, computed from these counts. The monitor compares it at the falling edge of exactly that cycle, and for several results it also checks the cycle just before to make sure the value does not arrive early.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  // bits needed to hold a count from 0 up to n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/supmon_dcnt.sv
module supmon_dcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)                  cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/supmon_cfg.sv
module supmon_cfg (
  input  logic clk,
  input  logic por,
  input  logic wr_en,
  input  logic wr_en_d,
  input  logic wr_src,
  input  logic wr_src_d,
  output logic en_q,
  output logic sel_q,
  output logic en_rise
);
  // only power-on touches these besides explicit writes
  always_ff @(posedge clk) begin
    if (por) begin
      en_q  <= 1'b1;
      sel_q <= 1'b1;
    end else begin
      if (wr_en)  en_q  <= wr_en_d;
      if (wr_src) sel_q <= wr_src_d;
    end
  end

  assign en_rise = wr_en && wr_en_d && !en_q;
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl #(
  parameter int POR_DLY     = 1024,
  parameter int STAB_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_i,
  input  logic vlow_async_i,
  input  logic swrst_req_i,
  input  logic wr_en_i,
  input  logic wr_en_data_i,
  input  logic wr_src_i,
  input  logic wr_src_data_i,
  output logic core_rst_n_o,
  output logic pin_rst_n_o,
  output logic flag_o,
  output logic mon_en_o,
  output logic mon_rdy_o
);
  import supmon_pkg::*;

  localparam int PW = cnt_width(POR_DLY);
  localparam int SW = cnt_width(STAB_CYC);

  logic vlow_s;
  logic en_q, sel_q, en_rise;
  logic stab_zero, por_zero;
  logic rdy_q, flag_q, core_q, pin_q;
  logic trip, hold;

  supmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .clr (por_i),
    .d   (vlow_async_i),
    .q   (vlow_s)
  );

  supmon_cfg u_cfg (
    .clk      (clk),
    .por      (por_i),
    .wr_en    (wr_en_i),
    .wr_en_d  (wr_en_data_i),
    .wr_src   (wr_src_i),
    .wr_src_d (wr_src_data_i),
    .en_q     (en_q),
    .sel_q    (sel_q),
    .en_rise  (en_rise)
  );

  // settling window: restarted on power-on and on every off-to-on write
  supmon_dcnt #(.W(SW)) u_stab (
    .clk      (clk),
    .load     (por_i || en_rise),
    .load_val (SW'(STAB_CYC)),
    .dec      (en_q),
    .zero     (stab_zero)
  );

  // start-up delay: only a real power-on loads it
  supmon_dcnt #(.W(PW)) u_pdly (
    .clk      (clk),
    .load     (por_i),
    .load_val (PW'(POR_DLY)),
    .dec      (1'b1),
    .zero     (por_zero)
  );

  assign trip = vlow_s && en_q && sel_q && rdy_q;
  assign hold = por_i || !por_zero || trip || swrst_req_i;

  always_ff @(posedge clk) begin
    if (por_i) begin
      rdy_q  <= 1'b0;
      flag_q <= 1'b1;
      core_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      rdy_q  <= en_q && stab_zero;
      core_q <= !hold;
      pin_q  <= !hold;
      if (trip)             flag_q <= 1'b1;
      else if (swrst_req_i) flag_q <= 1'b0;
    end
  end

  assign core_rst_n_o = core_q;
  assign pin_rst_n_o  = pin_q;
  assign flag_o       = flag_q;
  assign mon_en_o     = en_q;
  assign mon_rdy_o    = rdy_q;
endmodule

// File: rtl/supmon_chk.sv
module supmon_chk (
  input logic clk,
  input logic por_i,
  input logic swrst_req_i,
  input logic wr_en_i,
  input logic wr_en_data_i,
  input logic core_rst_n_o,
  input logic pin_rst_n_o,
  input logic flag_o,
  input logic mon_en_o,
  input logic mon_rdy_o
);
  a_r3_por_sets_state: assert property (@(posedge clk)
    por_i |=> (mon_en_o && flag_o));

  a_r4_por_holds_reset: assert property (@(posedge clk)
    por_i |=> (!core_rst_n_o && !pin_rst_n_o));

  a_r5_sw_keeps_enable: assert property (@(posedge clk) disable iff (por_i)
    (swrst_req_i && !wr_en_i) |=> (mon_en_o == $past(mon_en_o)));

  a_r5_sw_asserts_reset: assert property (@(posedge clk) disable iff (por_i)
    swrst_req_i |=> (!core_rst_n_o && !pin_rst_n_o));

  a_r6_enable_write: assert property (@(posedge clk) disable iff (por_i)
    wr_en_i |=> (mon_en_o == $past(wr_en_data_i)));

  a_r9_ready_needs_enable: assert property (@(posedge clk) disable iff (por_i)
    !mon_en_o |=> !mon_rdy_o);
endmodule

bind supmon_rst_ctrl supmon_chk u_chk (
  .clk          (clk),
  .por_i        (por_i),
  .swrst_req_i  (swrst_req_i),
  .wr_en_i      (wr_en_i),
  .wr_en_data_i (wr_en_data_i),
  .core_rst_n_o (core_rst_n_o),
  .pin_rst_n_o  (pin_rst_n_o),
  .flag_o       (flag_o),
  .mon_en_o     (mon_en_o),
  .mon_rdy_o    (mon_rdy_o)
);

// File: tb/sim_supmon_rst_ctrl.sv
`timescale 1ns/1ps
module sim_supmon_rst_ctrl;
  localparam int PD = 16;
  localparam int ST = 8;

  logic clk = 1'b0;
  logic por_i = 1'b1;
  logic vlow = 1'b0, swrst = 1'b0;
  logic wr_en = 1'b0, wr_en_d = 1'b0, wr_src = 1'b0, wr_src_d = 1'b0;
  logic core_n, pin_n, flag, en, rdy;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  supmon_rst_ctrl #(.POR_DLY(PD), .STAB_CYC(ST), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_i(por_i), .vlow_async_i(vlow), .swrst_req_i(swrst),
    .wr_en_i(wr_en), .wr_en_data_i(wr_en_d), .wr_src_i(wr_src),
    .wr_src_data_i(wr_src_d), .core_rst_n_o(core_n), .pin_rst_n_o(pin_n),
    .flag_o(flag), .mon_en_o(en), .mon_rdy_o(rdy)
  );

  function automatic logic sig_val(input int s);
    case (s)
      0: return core_n;
      1: return pin_n;
      2: return flag;
      3: return en;
      default: return rdy;
    endcase
  endfunction

  // driver side: schedule an expected value ofs cycles from now
  task automatic expect_at(input int ofs, input int s, input logic v, input string tag);
    exp_t e;
    e.due = cyc + ofs; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_rst(input int ofs, input logic v, input string tag);
    expect_at(ofs, 0, v, tag);
    expect_at(ofs, 1, v, tag);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // monitor side: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (sig_val(q[i].sig) !== q[i].val) begin
          errors++;
          $display("FAIL %s cycle %0d signal %0d actual %b expected %b",
                   q[i].tag, cyc, q[i].sig, sig_val(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    step(3);
    // R3: reset state while power-on is high
    expect_rst(0, 1'b0, "R4");
    expect_at(0, 2, 1'b1, "R3");
    expect_at(0, 3, 1'b1, "R3");
    por_i = 1'b0;
    expect_rst(PD, 1'b0, "R4");
    expect_rst(PD + 1, 1'b1, "R4");
    expect_at(ST, 4, 1'b0, "R7");
    expect_at(ST + 1, 4, 1'b1, "R7");
    step(PD + 4);

    // R5 / R10: software reset clears flag, keeps enable
    swrst = 1'b1;
    expect_rst(1, 1'b0, "R5");
    expect_at(1, 2, 1'b0, "R10");
    expect_at(1, 3, 1'b1, "R5");
    step(1);
    swrst = 1'b0;
    expect_rst(1, 1'b1, "R5");
    step(3);

    // R1 / R10: supply-fail trip
    vlow = 1'b1;
    expect_rst(2, 1'b1, "R1");
    expect_rst(3, 1'b0, "R1");
    expect_at(3, 2, 1'b1, "R10");
    expect_rst(6, 1'b0, "R1");
    step(6);
    // R2: release without start-up delay
    vlow = 1'b0;
    expect_rst(2, 1'b0, "R2");
    expect_rst(3, 1'b1, "R2");
    step(5);

    // R6 / R9: disable monitor, comparator ignored
    wr_en = 1'b1; wr_en_d = 1'b0;
    expect_at(1, 3, 1'b0, "R6");
    expect_at(2, 4, 1'b0, "R9");
    step(1);
    wr_en = 1'b0;
    step(2);
    vlow = 1'b1;
    expect_rst(3, 1'b1, "R9");
    expect_rst(5, 1'b1, "R9");
    step(6);
    vlow = 1'b0;
    step(4);
    // R5: software reset keeps a cleared enable
    swrst = 1'b1;
    expect_at(1, 3, 1'b0, "R5");
    step(1);
    swrst = 1'b0;
    expect_at(1, 3, 1'b0, "R5");
    step(3);

    // R7: re-enable, trip blocked until ready
    wr_en = 1'b1; wr_en_d = 1'b1;
    expect_at(1, 3, 1'b1, "R6");
    expect_at(ST + 1, 4, 1'b0, "R7");
    expect_at(ST + 2, 4, 1'b1, "R7");
    step(1);
    wr_en = 1'b0;
    vlow = 1'b1;
    expect_rst(8, 1'b1, "R7");
    expect_rst(9, 1'b1, "R7");
    expect_rst(10, 1'b0, "R1");
    step(12);
    vlow = 1'b0;
    step(5);

    // R8: deselect, comparator ignored; reselect, trip returns
    wr_src = 1'b1; wr_src_d = 1'b0;
    step(1);
    wr_src = 1'b0;
    vlow = 1'b1;
    expect_rst(3, 1'b1, "R8");
    expect_rst(5, 1'b1, "R8");
    step(6);
    wr_src = 1'b1; wr_src_d = 1'b1;
    step(1);
    wr_src = 1'b0;
    expect_rst(3, 1'b0, "R8");
    step(4);
    // R10: software reset during a trip keeps the flag
    swrst = 1'b1;
    expect_at(1, 2, 1'b1, "R10");
    step(1);
    swrst = 1'b0;
    vlow = 1'b0;
    expect_rst(3, 1'b1, "R2");
    step(5);

    // R3: power-on restores a cleared enable
    wr_en = 1'b1; wr_en_d = 1'b0;
    step(1);
    wr_en = 1'b0;
    expect_at(0, 3, 1'b0, "R6");
    step(1);
    por_i = 1'b1;
    expect_at(1, 3, 1'b1, "R3");
    expect_at(1, 2, 1'b1, "R3");
    expect_rst(1, 1'b0, "R4");
    step(2);
    por_i = 1'b0;
    step(3);

    foreach (q[i]) begin
      errors++;
      $display("FAIL %s never checked, expected %b", q[i].tag, q[i].val);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule